// File: doc/BRIEF.md
# Prioritized Interrupt Vector Resolver

This block turns a snapshot of three pending-interrupt words into a single interrupt vector number. It sits between the pending-status logic of an interrupt controller and the processor-side dispatch path. When `sample_i` is pulsed, it examines a basic pending word and two 32-bit peripheral bank words, picks exactly one source under a fixed two-level priority rule, and registers the resulting 8-bit vector together with a valid flag on the next clock edge.

The first level is a set of shortcut bits in the basic word, selected by a fixed eligibility mask. The lowest eligible bit wins and is translated through a fixed table. Some shortcut bits stand for the block's own basic sources, which sit above a configurable base number. The others are aliases of frequently used peripheral lines. When no shortcut bit is set, the resolver falls back to a lowest-bit-first search of peripheral bank 1 and then of bank 2. When nothing is pending at all, the output reads 255 with the valid flag low.

Top module: `irq_vector_resolver`

## Requirements
- R1: While `rst_ni` is low and after its release, `vector_o` reads 255 and `valid_o` reads 0 until the first sample.
- R2: The outputs change only on the clock edge that follows a cycle with `sample_i` high. With `sample_i` low, they keep their last value whatever the pending inputs do.
- R3: If any eligible shortcut bit of `basic_pend_i` is set, the result comes from the shortcut path, whatever the two banks hold.
- R4: The eligible shortcut bits are those set in mask 0x001FFCFF, which is bits 0..7 and 10..20. When several are set, the lowest index wins. Bits 8, 9 and 21..31 never select a shortcut.
- R5: Shortcut bits 0..7 translate to `BASIC_BASE` plus the bit index, which is 64..71 by default.
- R6: Shortcut bits 10 through 20 translate, in ascending bit order, to vectors 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62.
- R7: With no eligible shortcut bit set and bank 1 non-zero, the vector is the index (0..31) of the lowest set bit of `bank1_pend_i`, whatever bank 2 holds.
- R8: With no eligible shortcut bit and bank 1 all zero, a non-zero bank 2 gives vector 32 plus the index of its lowest set bit (32..63).
- R9: With nothing eligible and both banks zero, the sample yields vector 255 with `valid_o` low.
- R10: `valid_o` is high exactly when `vector_o` is not 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Strobe; resolve the current pending words |
| basic_pend_i | input | 32 | Basic pending word with shortcut and summary bits |
| bank1_pend_i | input | 32 | Peripheral pending bank 1 (sources 0..31) |
| bank2_pend_i | input | 32 | Peripheral pending bank 2 (sources 32..63) |
| vector_o | output | 8 | Resolved vector number, 255 when none |
| valid_o | output | 1 | High when `vector_o` names a real source |

## Verification
A fault in the priority selection or in the translation table shows up as a wrong `vector_o` in the cycle right after the sample that hits it. The vector table therefore drives each shortcut alias, both bank edges (bits 0 and 31), and the overlap cases where two levels are pending together. A fault in the held state shows up as an output that moves while `sample_i` stays low, so directed tests change the inputs without a strobe and compare the outputs across several cycles. A mismatch between the vector and its valid flag is visible on every cycle, so it is checked alongside each sample.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

    // Sentinel vector meaning "no source pending"
    localparam int unsigned NO_VECTOR_VAL = 255;

    // Which priority level produced a result
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_SHORT = 2'd1,
        SRC_BANK1 = 2'd2,
        SRC_BANK2 = 2'd3
    } src_e;

    // Registered state of the resolver
    typedef struct packed {
        logic [7:0] vector;
        logic       valid;
        src_e       src;
    } resolve_t;

    // Alias targets for the shortcut bits above the basic sources,
    // indexed by (bit - 10)
    function automatic logic [7:0] alias_target(input logic [3:0] slot);
        logic [7:0] r;
        case (slot)
            4'd0:    r = 8'd7;
            4'd1:    r = 8'd9;
            4'd2:    r = 8'd10;
            4'd3:    r = 8'd18;
            4'd4:    r = 8'd19;
            4'd5:    r = 8'd53;
            4'd6:    r = 8'd54;
            4'd7:    r = 8'd55;
            4'd8:    r = 8'd56;
            4'd9:    r = 8'd57;
            4'd10:   r = 8'd62;
            default: r = 8'hFF;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irqr_lsb_encoder.sv
// Lowest-set-bit priority encoder built from one-hot isolation and OR trees.
module irqr_lsb_encoder #(
    parameter int unsigned WIDTH = 32,
    localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    logic [WIDTH-1:0] lowest_onehot;

    // Positions whose index has bit b set
    function automatic logic [WIDTH-1:0] sel_mask(input int unsigned b);
        logic [WIDTH-1:0] m;
        for (int unsigned i = 0; i < WIDTH; i++) begin
            m[i] = ((i >> b) & 1) != 0;
        end
        return m;
    endfunction

    always_comb begin
        lowest_onehot = req_i & (~req_i + WIDTH'(1));
    end

    assign found_o = |req_i;

    for (genvar b = 0; b < int'(IDX_W); b++) begin : g_idx_bit
        localparam logic [WIDTH-1:0] SEL = sel_mask(b);
        assign idx_o[b] = |(lowest_onehot & SEL);
    end

endmodule

// File: rtl/irqr_shortcut_xlate.sv
// First priority level: masked shortcut bits of the basic word, translated.
module irqr_shortcut_xlate
    import irqr_pkg::*;
#(
    parameter int unsigned          PEND_W        = 32,
    parameter int unsigned          VEC_W         = 8,
    parameter int unsigned          BASIC_BASE    = 64,
    parameter int unsigned          NUM_BASIC     = 8,
    parameter int unsigned          ALIAS_LO      = 10,
    parameter logic [PEND_W-1:0]    SHORTCUT_MASK = 32'h001F_FCFF,
    localparam int unsigned         IDX_W         = $clog2(PEND_W)
) (
    input  logic [PEND_W-1:0] basic_i,
    output logic              hit_o,
    output logic [VEC_W-1:0]  vector_o
);

    logic [PEND_W-1:0] eligible;
    logic [IDX_W-1:0]  win_idx;
    logic              win_found;
    logic [IDX_W-1:0]  alias_slot;

    assign eligible = basic_i & SHORTCUT_MASK;

    irqr_lsb_encoder #(
        .WIDTH (PEND_W)
    ) u_short_enc (
        .req_i   (eligible),
        .found_o (win_found),
        .idx_o   (win_idx)
    );

    assign alias_slot = win_idx - IDX_W'(ALIAS_LO);

    always_comb begin
        vector_o = VEC_W'(NO_VECTOR_VAL);
        if (win_found) begin
            if (int'(win_idx) < int'(NUM_BASIC)) begin
                vector_o = VEC_W'(BASIC_BASE) + VEC_W'(win_idx);
            end else begin
                vector_o = VEC_W'(alias_target(alias_slot[3:0]));
            end
        end
    end

    assign hit_o = win_found;

endmodule

// File: rtl/irq_vector_resolver.sv
// Two-level interrupt vector resolver with a registered result.
module irq_vector_resolver
    import irqr_pkg::*;
#(
    parameter int unsigned       PEND_W        = 32,
    parameter int unsigned       VEC_W         = 8,
    parameter int unsigned       NUM_BANKS     = 2,
    parameter int unsigned       BASIC_BASE    = 64,
    parameter logic [PEND_W-1:0] SHORTCUT_MASK = 32'h001F_FCFF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sample_i,
    input  logic [PEND_W-1:0] basic_pend_i,
    input  logic [PEND_W-1:0] bank1_pend_i,
    input  logic [PEND_W-1:0] bank2_pend_i,
    output logic [VEC_W-1:0]  vector_o,
    output logic              valid_o
);

    localparam int unsigned IDX_W = $clog2(PEND_W);
    localparam logic [VEC_W-1:0] NONE = VEC_W'(NO_VECTOR_VAL);

    logic [PEND_W-1:0] bank_word  [NUM_BANKS];
    logic              bank_found [NUM_BANKS];
    logic [IDX_W-1:0]  bank_idx   [NUM_BANKS];
    logic [VEC_W-1:0]  bank_vec   [NUM_BANKS];

    logic              short_hit;
    logic [VEC_W-1:0]  short_vec;

    resolve_t state_d, state_q;

    assign bank_word[0] = bank1_pend_i;
    assign bank_word[1] = bank2_pend_i;

    irqr_shortcut_xlate #(
        .PEND_W        (PEND_W),
        .VEC_W         (VEC_W),
        .BASIC_BASE    (BASIC_BASE),
        .SHORTCUT_MASK (SHORTCUT_MASK)
    ) u_shortcut (
        .basic_i  (basic_pend_i),
        .hit_o    (short_hit),
        .vector_o (short_vec)
    );

    for (genvar g = 0; g < int'(NUM_BANKS); g++) begin : g_bank
        irqr_lsb_encoder #(
            .WIDTH (PEND_W)
        ) u_bank_enc (
            .req_i   (bank_word[g]),
            .found_o (bank_found[g]),
            .idx_o   (bank_idx[g])
        );
        assign bank_vec[g] = VEC_W'(g * PEND_W) + VEC_W'(bank_idx[g]);
    end

    always_comb begin
        state_d = state_q;
        if (sample_i) begin
            if (short_hit) begin
                state_d.vector = short_vec;
                state_d.src    = SRC_SHORT;
            end else if (bank_found[0]) begin
                state_d.vector = bank_vec[0];
                state_d.src    = SRC_BANK1;
            end else if (bank_found[1]) begin
                state_d.vector = bank_vec[1];
                state_d.src    = SRC_BANK2;
            end else begin
                state_d.vector = NONE;
                state_d.src    = SRC_NONE;
            end
            state_d.valid = (state_d.vector != NONE);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.vector <= NONE;
            state_q.valid  <= 1'b0;
            state_q.src    <= SRC_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    assign vector_o = state_q.vector;
    assign valid_o  = state_q.valid;

endmodule

// File: rtl/irq_vector_resolver_chk.sv
module irq_vector_resolver_chk #(
    parameter int unsigned       PEND_W        = 32,
    parameter int unsigned       VEC_W         = 8,
    parameter logic [PEND_W-1:0] SHORTCUT_MASK = 32'h001F_FCFF
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sample_i,
    input logic [PEND_W-1:0] basic_pend_i,
    input logic [PEND_W-1:0] bank1_pend_i,
    input logic [PEND_W-1:0] bank2_pend_i,
    input logic [VEC_W-1:0]  vector_o,
    input logic              valid_o
);
    localparam logic [VEC_W-1:0] NONE = {VEC_W{1'b1}};

    logic no_short;
    assign no_short = (basic_pend_i & SHORTCUT_MASK) == '0;

    // R2: no strobe, no change
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sample_i |=> ($stable(vector_o) && $stable(valid_o)));

    // R7: bank 1 result lies in 0..31
    assert_bank1_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_i && no_short && bank1_pend_i != '0) |=> (vector_o < VEC_W'(PEND_W)));

    // R8: bank 2 result lies in 32..63
    assert_bank2_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_i && no_short && bank1_pend_i == '0 && bank2_pend_i != '0)
        |=> (vector_o >= VEC_W'(PEND_W) && vector_o < VEC_W'(2 * PEND_W)));

    // R9: nothing pending gives no dispatch
    assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_i && no_short && bank1_pend_i == '0 && bank2_pend_i == '0)
        |=> (!valid_o && vector_o == NONE));

    // R10: valid flag agrees with the vector
    assert_valid_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o == (vector_o != NONE));

endmodule

bind irq_vector_resolver irq_vector_resolver_chk #(
    .PEND_W        (PEND_W),
    .VEC_W         (VEC_W),
    .SHORTCUT_MASK (SHORTCUT_MASK)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sample_i     (sample_i),
    .basic_pend_i (basic_pend_i),
    .bank1_pend_i (bank1_pend_i),
    .bank2_pend_i (bank2_pend_i),
    .vector_o     (vector_o),
    .valid_o      (valid_o)
);

// File: tb/irq_vector_resolver_tb.sv
module irq_vector_resolver_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] basic;
        logic [31:0] b1;
        logic [31:0] b2;
        logic [7:0]  vec;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{32'h0000_0001, 32'h0000_0005, 32'h0,         8'd64,  4'd3}, // R3 R5
        '{32'h0000_0080, 32'h0,         32'h0,         8'd71,  4'd5}, // R5
        '{32'h0000_0300, 32'h0000_0010, 32'h0,         8'd4,   4'd4}, // R4 bits 8,9 ineligible
        '{32'h0000_0400, 32'h0,         32'h0,         8'd7,   4'd6}, // R6
        '{32'h0010_0000, 32'h0,         32'h0,         8'd62,  4'd6}, // R6 bit 20
        '{32'h0000_8000, 32'h0,         32'h0,         8'd53,  4'd6}, // R6 bit 15
        '{32'h0004_0000, 32'h0,         32'h0,         8'd56,  4'd6}, // R6 bit 18
        '{32'h0000_0C00, 32'h0,         32'h0,         8'd7,   4'd4}, // R4 lowest wins
        '{32'h0001_0800, 32'hFFFF_FFFF, 32'h1,         8'd9,   4'd4}, // R4 R3
        '{32'h8000_0000, 32'h8000_0000, 32'h0,         8'd31,  4'd7}, // R7 bit 31 ineligible
        '{32'h0,         32'h0000_0006, 32'h0,         8'd1,   4'd7}, // R7
        '{32'h0,         32'h0000_0100, 32'h0000_0001, 8'd8,   4'd8}, // R8 bank 1 first
        '{32'h0,         32'h0,         32'h0000_0001, 8'd32,  4'd8}, // R8
        '{32'h0,         32'h0,         32'h8000_0000, 8'd63,  4'd8}, // R8
        '{32'h0,         32'h0,         32'h0,         8'd255, 4'd9}, // R9
        '{32'h0020_0300, 32'h0,         32'h0,         8'd255, 4'd9}, // R9 R4 only ineligible bits
        '{32'h0000_00C0, 32'h0,         32'h0,         8'd70,  4'd5}  // R5
    };

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        sample_i = 1'b0;
    logic [31:0] basic_pend_i = '0;
    logic [31:0] bank1_pend_i = '0;
    logic [31:0] bank2_pend_i = '0;
    logic [7:0]  vector_o;
    logic        valid_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    irq_vector_resolver u_dut (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sample_i     (sample_i),
        .basic_pend_i (basic_pend_i),
        .bank1_pend_i (bank1_pend_i),
        .bank2_pend_i (bank2_pend_i),
        .vector_o     (vector_o),
        .valid_o      (valid_o)
    );

    task automatic check(input string tag, input logic [7:0] exp_vec);
        logic exp_valid;
        exp_valid = (exp_vec != 8'd255); // R10
        n_checks++;
        if (vector_o !== exp_vec || valid_o !== exp_valid) begin
            n_fail++;
            $display("FAIL %s: vector=%0d valid=%0b expected vector=%0d valid=%0b",
                     tag, vector_o, valid_o, exp_vec, exp_valid);
        end
    endtask

    task automatic strobe(input logic [31:0] bw, input logic [31:0] w1, input logic [31:0] w2);
        @(negedge clk_i);
        basic_pend_i = bw;
        bank1_pend_i = w1;
        bank2_pend_i = w2;
        sample_i = 1'b1;
        @(negedge clk_i);
        sample_i = 1'b0;
    endtask

    initial begin
        // R1: reset state
        #(CLK_PERIOD * 2);
        check("R1 during reset", 8'd255);
        @(negedge clk_i);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);
        check("R1 after release", 8'd255);

        for (int i = 0; i < NV; i++) begin
            strobe(TBL[i].basic, TBL[i].b1, TBL[i].b2);
            check($sformatf("R%0d/R10 row %0d", TBL[i].req, i), TBL[i].vec);
        end

        // R2: inputs change without strobe, output holds
        strobe(32'h0, 32'h0000_0020, 32'h0);
        check("R2 load", 8'd5);
        @(negedge clk_i);
        basic_pend_i = 32'h0000_0001;
        bank1_pend_i = 32'h0;
        bank2_pend_i = 32'h0;
        repeat (3) @(negedge clk_i);
        check("R2 hold", 8'd5);
        // R2: strobe then picks up the new words
        strobe(basic_pend_i, bank1_pend_i, bank2_pend_i);
        check("R2 resample", 8'd64);

        // R1: reset mid-run clears result
        @(negedge clk_i);
        rst_ni = 1'b0;
        @(negedge clk_i);
        check("R1 reassert", 8'd255);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 re-release", 8'd255);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk_i);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule